// File: doc/BRIEF.md
# Per-Channel Sample Capture with Trigger Tagging

This block serves one channel of a multi-channel digital oscilloscope in real-time sampling mode. A programmable divider paces the ADC: every `cfg_div + 1` system clocks it issues a sample strobe, and on that edge the channel's 8-bit ADC word is written into a private 4096-deep FIFO. A design with several channels instantiates the block once per channel, so every channel acquires into its own buffer in parallel. The block also owns the ADC power state: in power-down the ADC clock enable is dropped and acquisition stops.

Trigger candidates come from an external edge detector, which supplies rise and fall flags for every channel. The configuration picks the trigger channel and the slope. A candidate is confirmed only if the selected channel's sample at the next strobe moves in the requested direction relative to the sample taken at the strobe before it. A confirmed trigger marks the next word written to the FIFO by setting its ninth bit. A downstream reader can then find where the triggered record starts. After one trigger the block ignores further triggers until it receives a rearm pulse.

Top module: `chan_capture`

## Requirements
- R1: With the ADC powered, `adc_sample_stb` is high for one clock in every `cfg_div + 1` clocks. With `cfg_div = 0` it is high on every clock.
- R2: On each clock edge where `adc_sample_stb` is high and the FIFO accepts a write, the stored word is `{tag, adc_data}`. Bits 7:0 hold the ADC word present at that edge, and bit 8 holds the tag.
- R3: A trigger is confirmed at a strobe under four conditions. A candidate must be pending, taken from `edge_rise[cfg_trig_ch]` when `cfg_trig_fall = 0` or from `edge_fall[cfg_trig_ch]` when it is 1, with an edge in the strobe cycle also counting. The block must be armed, and no earlier tag may still be pending. The selected channel's slice of `ref_data` must be strictly greater than its previous strobe value for a rising trigger, or strictly less for a falling one.
- R4: Bit 8 is 1 on exactly the first word written after the strobe that confirmed the trigger. The word written at the confirming strobe carries 0.
- R5: Once a trigger is confirmed, further edges confirm nothing until `rearm` has been pulsed.
- R6: After reset, and after leaving power-down, the first strobe cannot confirm a trigger, because no previous sample exists yet.
- R7: One clock after `cfg_pwr_down` is set, `adc_clk_en` is 0, `adc_pwr_dn` is 1, no strobe fires and nothing is written.
- R8: A strobe while the FIFO is full writes nothing and sets `overflow`, which stays set until reset. A strobe while the FIFO is full but a read is accepted in the same cycle is written.
- R9: `rd_data` shows the oldest word. `rd_en` while not empty removes it. `rd_empty` and `rd_full` report zero and 4096 stored words, and a read while empty changes nothing.
- R10: Edge flags on channels other than `cfg_trig_ch`, or of the slope not selected, never confirm a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pwr_down | input | 1 | 1 puts the ADC in power-down |
| cfg_div | input | 16 | Sample-rate divider N, period N+1 clocks |
| cfg_trig_ch | input | 1 | Trigger source channel index |
| cfg_trig_fall | input | 1 | 0 rising-slope trigger, 1 falling-slope trigger |
| rearm | input | 1 | Pulse to allow the next trigger |
| edge_rise | input | 2 | Rise flags from the edge detector, one per channel |
| edge_fall | input | 2 | Fall flags from the edge detector, one per channel |
| ref_data | input | 16 | Current ADC words of all channels, channel k in bits 8k+7:8k |
| adc_data | input | 8 | This channel's ADC word |
| adc_clk_en | output | 1 | ADC clock enable, low in power-down |
| adc_pwr_dn | output | 1 | ADC power-down control |
| adc_sample_stb | output | 1 | Sample strobe; data is taken at this edge |
| rd_en | input | 1 | Read request from the consumer |
| rd_data | output | 9 | Oldest stored word, tag in bit 8 |
| rd_empty | output | 1 | FIFO holds no word |
| rd_full | output | 1 | FIFO holds 4096 words |
| overflow | output | 1 | Sticky flag, a sample was dropped |

## Verification
Two functions can meet in one cycle. A FIFO read can coincide with a strobe while the buffer is full, and trigger confirmation can coincide with the write of the sample at that strobe. The bench sets the divider to zero, fills the buffer and pulses one read while strobes keep firing. It then checks at the next falling edge that the buffer still reports full, which shows the strobe's write was accepted because the read freed a slot. For the trigger, it places the edge flag in the strobe cycle itself. It then expects the word stored at that strobe to be untagged and the following word to be tagged.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int SAMPLE_W = 8;
  localparam int WORD_W   = SAMPLE_W + 1;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [WORD_W-1:0]   word_t;

  // slope comparison that qualifies a candidate trigger
  function automatic logic slope_ok(input logic falling, input sample_t cur, input sample_t prev);
    return falling ? (cur < prev) : (cur > prev);
  endfunction

  // stored word: tag above the sample
  function automatic word_t pack_word(input logic tag, input sample_t s);
    return {tag, s};
  endfunction

  // divider wraps once the count reaches the programmed limit
  function automatic logic div_wrap(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/cap_rate_gen.sv
module cap_rate_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic [DIV_W-1:0] div,
  output logic             stb
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = cap_pkg::div_wrap(32'(cnt), 32'(div));
  assign stb  = !pd && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (pd)    cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cap_trig_qual.sv
module cap_trig_qual #(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pd,
  input  logic                              stb,
  input  logic                              tag_written,
  input  logic [CH_W-1:0]                   cfg_ch,
  input  logic                              cfg_fall,
  input  logic                              rearm,
  input  logic [NCH-1:0]                    edge_rise,
  input  logic [NCH-1:0]                    edge_fall,
  input  logic [NCH*cap_pkg::SAMPLE_W-1:0]  ref_data,
  output logic                              found,
  output logic                              confirm
);
  import cap_pkg::*;

  logic    armed, cand_q, prev_valid;
  sample_t prev, cur;
  logic    ch_ok, edge_sel, edge_hit, cand;

  assign ch_ok    = 32'(cfg_ch) < NCH;
  assign edge_sel = ch_ok && (cfg_fall ? edge_fall[cfg_ch] : edge_rise[cfg_ch]);
  assign edge_hit = armed && !found && edge_sel;
  assign cur      = ch_ok ? ref_data[32'(cfg_ch)*SAMPLE_W +: SAMPLE_W] : '0;
  assign cand     = cand_q || edge_hit;
  assign confirm  = stb && cand && prev_valid && slope_ok(cfg_fall, cur, prev);

  always_ff @(posedge clk) begin
    if (!rst_n)          cand_q <= 1'b0;
    else if (pd || stb)  cand_q <= 1'b0;
    else                 cand_q <= cand;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev       <= '0;
      prev_valid <= 1'b0;
    end else if (pd) begin
      prev_valid <= 1'b0;
    end else if (stb) begin
      prev       <= cur;
      prev_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    found <= 1'b0;
    else if (confirm)              found <= 1'b1;
    else if (tag_written)          found <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b1;
    else if (confirm)  armed <= 1'b0;
    else if (rearm)    armed <= 1'b1;
  end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int ADDR_W = 12,
  parameter int W      = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         wr_fire,
  output logic         ovf_evt
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0]      mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr;
  logic [ADDR_W:0]   count;
  logic              rd_fire;

  assign empty   = (count == '0);
  assign full    = (count == (ADDR_W+1)'(DEPTH));
  assign rd_fire = rd_req && !empty;
  assign wr_fire = wr_req && (!full || rd_fire);
  assign ovf_evt = wr_req && full && !rd_fire;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rd_fire) rptr <= rptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/chan_capture.sv
module chan_capture #(
  parameter int NCH    = 2,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW    = cap_pkg::SAMPLE_W,
  localparam int WW    = cap_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pwr_down,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CH_W-1:0]   cfg_trig_ch,
  input  logic              cfg_trig_fall,
  input  logic              rearm,
  input  logic [NCH-1:0]    edge_rise,
  input  logic [NCH-1:0]    edge_fall,
  input  logic [NCH*SW-1:0] ref_data,
  input  logic [SW-1:0]     adc_data,
  output logic              adc_clk_en,
  output logic              adc_pwr_dn,
  output logic              adc_sample_stb,
  input  logic              rd_en,
  output logic [WW-1:0]     rd_data,
  output logic              rd_empty,
  output logic              rd_full,
  output logic              overflow
);
  import cap_pkg::*;

  // named internal events, observed by the bound checker
  logic  pd_q;
  logic  trig_found, trig_confirm;
  logic  wr_fire, wr_tag, ovf_evt, tag_written;
  word_t wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= cfg_pwr_down;
  end

  assign adc_clk_en = !pd_q;
  assign adc_pwr_dn = pd_q;

  cap_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk (clk),
    .rst_n (rst_n),
    .pd  (pd_q),
    .div (cfg_div),
    .stb (adc_sample_stb)
  );

  assign wr_tag      = trig_found;
  assign wr_word     = pack_word(wr_tag, adc_data);
  assign tag_written = wr_fire && wr_tag;

  cap_trig_qual #(.NCH(NCH), .CH_W(CH_W)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd          (pd_q),
    .stb         (adc_sample_stb),
    .tag_written (tag_written),
    .cfg_ch      (cfg_trig_ch),
    .cfg_fall    (cfg_trig_fall),
    .rearm       (rearm),
    .edge_rise   (edge_rise),
    .edge_fall   (edge_fall),
    .ref_data    (ref_data),
    .found       (trig_found),
    .confirm     (trig_confirm)
  );

  cap_fifo #(.ADDR_W(ADDR_W), .W(WW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (adc_sample_stb),
    .wr_data (wr_word),
    .rd_req  (rd_en),
    .rd_data (rd_data),
    .empty   (rd_empty),
    .full    (rd_full),
    .wr_fire (wr_fire),
    .ovf_evt (ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (ovf_evt) overflow <= 1'b1;
  end
endmodule

// File: rtl/chan_capture_chk.sv
module chan_capture_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_clk_en,
  input logic             adc_sample_stb,
  input logic [DIV_W-1:0] cfg_div,
  input logic             rd_en,
  input logic             rd_empty,
  input logic             rd_full,
  input logic             overflow,
  input logic             wr_fire,
  input logic             wr_tag,
  input logic             trig_found,
  input logic             trig_confirm
);
  // R7
  pd_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_clk_en |-> !adc_sample_stb);
  // R1
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sample_stb && cfg_div != '0) |=> !adc_sample_stb);
  // R8
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sample_stb && rd_full && !rd_en) |=> overflow);
  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R4
  tag_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_tag) |=> !trig_found);
  // R4
  confirm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_confirm |=> trig_found);
  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_empty && rd_full));
  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_empty && !wr_fire) |=> rd_empty);
endmodule

bind chan_capture chan_capture_chk #(.DIV_W(DIV_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .adc_clk_en     (adc_clk_en),
  .adc_sample_stb (adc_sample_stb),
  .cfg_div        (cfg_div),
  .rd_en          (rd_en),
  .rd_empty       (rd_empty),
  .rd_full        (rd_full),
  .overflow       (overflow),
  .wr_fire        (wr_fire),
  .wr_tag         (wr_tag),
  .trig_found     (trig_found),
  .trig_confirm   (trig_confirm)
);

// File: tb/test_chan_capture.sv
module test_chan_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pwr_down = 1'b0;
  logic [15:0] cfg_div = 16'd3;
  logic [0:0]  cfg_trig_ch = 1'b0;
  logic        cfg_trig_fall = 1'b0;
  logic        rearm = 1'b0;
  logic [1:0]  edge_rise = '0, edge_fall = '0;
  logic [15:0] ref_data = '0;
  logic [7:0]  adc_data = '0;
  logic        adc_clk_en, adc_pwr_dn, adc_sample_stb;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_data;
  logic        rd_empty, rd_full, overflow;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_capture i_chan_capture (
    .clk(clk), .rst_n(rst_n), .cfg_pwr_down(cfg_pwr_down), .cfg_div(cfg_div),
    .cfg_trig_ch(cfg_trig_ch), .cfg_trig_fall(cfg_trig_fall), .rearm(rearm),
    .edge_rise(edge_rise), .edge_fall(edge_fall), .ref_data(ref_data),
    .adc_data(adc_data), .adc_clk_en(adc_clk_en), .adc_pwr_dn(adc_pwr_dn),
    .adc_sample_stb(adc_sample_stb), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_full(rd_full), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_stb();
    forever begin
      @(negedge clk);
      if (adc_sample_stb) break;
    end
  endtask

  // one sample: inputs set just before the strobe edge
  task automatic sample(input logic [7:0] own, input logic [7:0] c0, input logic [7:0] c1,
                        input logic [1:0] rise, input logic [1:0] fall);
    wait_stb();
    adc_data  = own;
    ref_data  = {c1, c0};
    edge_rise = rise;
    edge_fall = fall;
    @(negedge clk);
    edge_rise = '0;
    edge_fall = '0;
  endtask

  task automatic freeze();
    @(negedge clk);
    cfg_pwr_down = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop(output logic [8:0] w);
    @(negedge clk);
    w = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_word(input string req, input logic [8:0] exp);
    logic [8:0] w;
    check({req, " not empty"}, int'(rd_empty), 0);
    pop(w);
    check(req, int'(w), int'(exp));
  endtask

  task automatic drain();
    logic [8:0] w;
    @(negedge clk);
    while (!rd_empty) pop(w);
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 empty after reset", int'(rd_empty), 1);
    check("R9 full after reset", int'(rd_full), 0);
    check("R8 overflow after reset", int'(overflow), 0);
    check("R7 clk_en while powered down", int'(adc_clk_en), 0);
    check("R7 pwr_dn while powered down", int'(adc_pwr_dn), 1);
  endtask

  task automatic t_rate();
    int gap;
    cfg_div = 16'd3;
    cfg_pwr_down = 1'b0;
    wait_stb();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!adc_sample_stb);
    check("R1 period div=3", gap, 4);
    cfg_div = 16'd0;
    wait_stb();
    @(negedge clk);
    check("R1 strobe every clock div=0", int'(adc_sample_stb), 1);
    cfg_div = 16'd3;
    freeze();
    drain();
  endtask

  // R3 R4: rising trigger on channel 0, edge in the strobe cycle
  task automatic t_rising();
    cfg_trig_ch = 1'b0; cfg_trig_fall = 1'b0;
    cfg_pwr_down = 1'b0;
    sample(8'h11, 8'd10, 8'd0, 2'b00, 2'b00);
    sample(8'h22, 8'd20, 8'd0, 2'b01, 2'b00);
    sample(8'h33, 8'd5,  8'd0, 2'b00, 2'b00);
    sample(8'h44, 8'd6,  8'd0, 2'b00, 2'b00);
    freeze();
    expect_word("R2 plain sample", 9'h011);
    expect_word("R4 confirming sample untagged", 9'h022);
    expect_word("R4 next sample tagged", 9'h133);
    expect_word("R4 only one tag", 9'h044);
    drain();
    pulse_rearm();
  endtask

  // R3 R10: falling trigger on channel 1
  task automatic t_falling();
    cfg_trig_ch = 1'b1; cfg_trig_fall = 1'b1;
    cfg_pwr_down = 1'b0;
    sample(8'hA0, 8'd0,  8'd50, 2'b00, 2'b00);
    sample(8'hA1, 8'd0,  8'd60, 2'b00, 2'b10);
    sample(8'hA2, 8'd0,  8'd40, 2'b10, 2'b01);
    sample(8'hA3, 8'd0,  8'd40, 2'b00, 2'b10);
    sample(8'hA4, 8'd0,  8'd30, 2'b00, 2'b10);
    sample(8'hA5, 8'd0,  8'd31, 2'b00, 2'b00);
    sample(8'hA6, 8'd0,  8'd32, 2'b00, 2'b00);
    freeze();
    expect_word("R2 prime", 9'h0A0);
    expect_word("R3 fall flag but value rose", 9'h0A1);
    expect_word("R10 wrong channel and slope", 9'h0A2);
    expect_word("R3 equal value no confirm", 9'h0A3);
    expect_word("R4 falling confirm untagged", 9'h0A4);
    expect_word("R3 falling confirm tags next", 9'h1A5);
    expect_word("R4 single tag falling", 9'h0A6);
    drain();
    pulse_rearm();
  endtask

  // R5: no retrigger before rearm
  task automatic t_rearm();
    cfg_trig_ch = 1'b0; cfg_trig_fall = 1'b0;
    cfg_pwr_down = 1'b0;
    sample(8'h01, 8'd10, 8'd0, 2'b00, 2'b00);
    sample(8'h02, 8'd20, 8'd0, 2'b01, 2'b00);
    sample(8'h03, 8'd30, 8'd0, 2'b01, 2'b00);
    sample(8'h04, 8'd40, 8'd0, 2'b01, 2'b00);
    sample(8'h05, 8'd50, 8'd0, 2'b00, 2'b00);
    pulse_rearm();
    sample(8'h06, 8'd60, 8'd0, 2'b01, 2'b00);
    sample(8'h07, 8'd70, 8'd0, 2'b00, 2'b00);
    freeze();
    expect_word("R5 prime", 9'h001);
    expect_word("R5 confirm", 9'h002);
    expect_word("R5 tagged", 9'h103);
    expect_word("R5 disarmed edge ignored", 9'h004);
    expect_word("R5 disarmed idle", 9'h005);
    expect_word("R5 confirm after rearm", 9'h006);
    expect_word("R5 tagged after rearm", 9'h107);
    drain();
    pulse_rearm();
  endtask

  // R6 R7: power-down stops capture and invalidates the previous sample
  task automatic t_powerdown();
    int stbs;
    cfg_trig_ch = 1'b0; cfg_trig_fall = 1'b0;
    cfg_pwr_down = 1'b0;
    sample(8'h51, 8'd10, 8'd0, 2'b00, 2'b00);
    freeze();
    check("R7 clk_en low", int'(adc_clk_en), 0);
    check("R7 pwr_dn high", int'(adc_pwr_dn), 1);
    stbs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (adc_sample_stb) stbs++;
    end
    check("R7 no strobes in power-down", stbs, 0);
    expect_word("R7 only pre-powerdown word", 9'h051);
    check("R7 nothing written in power-down", int'(rd_empty), 1);
    cfg_pwr_down = 1'b0;
    sample(8'h52, 8'd100, 8'd0, 2'b01, 2'b00);
    sample(8'h53, 8'd110, 8'd0, 2'b01, 2'b00);
    sample(8'h54, 8'd111, 8'd0, 2'b00, 2'b00);
    freeze();
    expect_word("R6 first sample after wake cannot confirm", 9'h052);
    expect_word("R6 confirm on second sample", 9'h053);
    expect_word("R6 tag after wake", 9'h154);
    drain();
    pulse_rearm();
  endtask

  // R8 R9: fill, overflow, read and write in the same full cycle, drain
  task automatic t_overflow();
    int n;
    logic [8:0] w;
    adc_data = 8'h77;
    cfg_div = 16'd0;
    cfg_pwr_down = 1'b0;
    repeat (4096 + 10) @(negedge clk);
    check("R9 full after 4096 writes", int'(rd_full), 1);
    check("R8 overflow set", int'(overflow), 1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 write accepted with read while full", int'(rd_full), 1);
    freeze();
    n = 0;
    while (!rd_empty && n < 5000) begin pop(w); n++; end
    check("R9 words drained", n, 4096);
    check("R8 overflow sticky", int'(overflow), 1);
    check("R9 empty after drain", int'(rd_empty), 1);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 read while empty keeps empty", int'(rd_empty), 1);
    check("R9 read while empty keeps not full", int'(rd_full), 0);
    cfg_div = 16'd3;
  endtask

  initial begin
    cfg_pwr_down = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rate();
    t_rising();
    t_falling();
    t_rearm();
    t_powerdown();
    t_overflow();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule